// File: doc/BRIEF.md
# Dual-Port Video Memory Address Stepper

This block sits between a byte-wide processor register interface and a video memory array. It holds two independent 17-bit address pointers. A processor reaches video memory only through two data registers, one per pointer. Each access to a data register becomes a single memory request at that pointer's current address. When the memory completes the request, the pointer moves by a programmed stride.

Each pointer has three address registers: a low byte, a middle byte and a high byte. A select bit in a control register decides which pointer those three registers show and load. The high byte also holds the pointer's direction flag and its 4-bit stride code. The stride codes cover powers of two up to 512 and also the row-sized strides 40, 80, 160, 320 and 640. This lets software walk a bitmap column by column without reloading the address.

The processor raises `cpu_req` for one cycle and waits for the one-cycle `cpu_ack`. Register accesses acknowledge on the next cycle. A data access holds `mem_req` until `mem_ready`, then acknowledges on the following cycle with the read byte.

Top module: `vram_addr_stepper`

## Requirements
- R1: After reset both pointers are zero, both stride codes and direction flags are zero, the select bit is zero, and `mem_req`, `cpu_ack` and `cpu_busy` are low.
- R2: Register indices 0, 1 and 2 read and load bits 7:0, bits 15:8 and the high byte of the pointer chosen by control bit 0 (index 5). The other pointer is left unchanged.
- R3: The high byte holds address bit 16 in bit 0, the decrement flag in bit 3 and the stride code in bits 7:4. Bits 2:1 of the high byte, bits 7:1 of the control register, and indices 6 and 7 all read as zero.
- R4: An access to index 3 (port 0) or index 4 (port 1) raises `mem_req` with `mem_addr` equal to that port's pointer before any step, with `mem_we` equal to the access direction and `mem_wdata` equal to the written byte. All of these stay stable until `mem_ready`.
- R5: In the cycle after `mem_ready` is seen with `mem_req`, `mem_req` falls, `cpu_ack` pulses, `cpu_rdata` carries `mem_rdata` for a read, and the pointer takes its new value. Exactly one memory request is made per data access.
- R6: Stride codes 0 to 10 move the pointer by 0, 1, 2, 4, 8, 16, 32, 64, 128, 256 and 512.
- R7: Stride codes 11 to 15 move the pointer by 40, 80, 160, 320 and 640.
- R8: With the decrement flag set, the stride is subtracted instead of added.
- R9: Pointer arithmetic wraps modulo 2^17 in both directions.
- R10: Port 0 accesses step only pointer 0 and port 1 accesses step only pointer 1, whatever the select bit holds.
- R11: While `cpu_busy` is high, a new `cpu_req` is ignored. No register changes and no extra acknowledge is produced.
- R12: Stride code 0 keeps the pointer fixed, so repeated accesses use the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | One-cycle access strobe from the processor |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | 3 | Register index (0 low, 1 mid, 2 high, 3 port 0, 4 port 1, 5 control) |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | A memory access is outstanding |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 17 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, sampled with `mem_ready` |
| mem_ready | input | 1 | Memory completion |

## Verification
The assertions check several properties on every cycle. The memory request stays stable while it waits, and its address matches the active pointer. The acknowledge follows `mem_ready`. An access on one port never moves the other pointer, and nothing changes while the block is busy. The exact stride for each code, the direction and the wrap at 2^17 can only be shown by the bench. It compares the address of each following request against its own stride table. Register layout, selection and read data are also shown only through the bench's random and directed scenarios.

// File: rtl/vstep_pkg.sv
// Shared constants for the address stepper: widths, port count and
// register index encoding. Assumes exactly a 17-bit address space.
package vstep_pkg;
    localparam int ADDR_W    = 17;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 3;
    localparam int CODE_W    = 4;
    localparam int NUM_PORTS = 2;
    localparam int PORT_W    = $clog2(NUM_PORTS);

    localparam logic [IDX_W-1:0] IDX_LO    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MID   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_HI    = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DATA0 = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DATA1 = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/vstep_stride.sv
// Stride decoder: turns a 4-bit stride code into an address increment.
// Codes 1..10 are powers of two (1..512), code 0 is zero, and codes
// 11..15 are 40 doubled per step. Purely combinational.
module vstep_stride
    import vstep_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] stride
);
    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ROW_BASE  = ADDR_W'(40);
    localparam logic [CODE_W-1:0] LAST_POW2 = CODE_W'(10);

    // Select the power-of-two or row-stride family from the code.
    always_comb begin
        if (code == '0)
            stride = '0;
        else if (code <= LAST_POW2)
            stride = ONE << (code - CODE_W'(1));
        else
            stride = ROW_BASE << (code - (LAST_POW2 + CODE_W'(1)));
    end
endmodule

// File: rtl/vstep_pointer.sv
// One address pointer with its direction flag and stride code.
// Assumes loads and steps are never requested in the same cycle
// (the controller guarantees this); a step wins if they are.
module vstep_pointer
    import vstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_mid,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              hi_bit,
    input  logic              hi_decr,
    input  logic [CODE_W-1:0] hi_code,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              decr,
    output logic [CODE_W-1:0] code
);
    logic [ADDR_W-1:0] stride;

    vstep_stride u_stride (
        .code   (code),
        .stride (stride)
    );

    // Hold the pointer: reset, step by the stride, or load a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            decr <= 1'b0;
            code <= '0;
        end else if (step) begin
            addr <= decr ? (addr - stride) : (addr + stride);
        end else begin
            if (ld_lo)
                addr[7:0] <= byte_in;
            if (ld_mid)
                addr[15:8] <= byte_in;
            if (ld_hi) begin
                addr[16] <= hi_bit;
                decr     <= hi_decr;
                code     <= hi_code;
            end
        end
    end
endmodule

// File: rtl/vstep_ctrl.sv
// Access controller: accepts one processor request at a time. Register
// accesses finish in one cycle; data accesses issue a held memory
// request and finish one cycle after mem_ready. Requests while busy
// are dropped. Assumes the pointer inputs are stable while waiting.
module vstep_ctrl
    import vstep_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cpu_req,
    input  logic                                cpu_we,
    input  logic [IDX_W-1:0]                    cpu_idx,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    input  logic [DATA_W-1:0]                   reg_rdata,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    ptr_addr,
    input  logic [DATA_W-1:0]                   mem_rdata,
    input  logic                                mem_ready,
    output logic                                reg_wr,
    output logic                                step_valid,
    output logic [PORT_W-1:0]                   act_port,
    output logic                                busy,
    output logic                                cpu_ack,
    output logic [DATA_W-1:0]                   cpu_rdata,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata
);
    ctrl_state_e       state;
    logic              accept;
    logic              is_data;
    logic [PORT_W-1:0] req_port;

    // Decode the incoming request.
    always_comb begin
        accept   = cpu_req && (state == ST_IDLE);
        is_data  = (cpu_idx >= IDX_DATA0) &&
                   (cpu_idx < IDX_DATA0 + IDX_W'(NUM_PORTS));
        req_port = PORT_W'(cpu_idx - IDX_DATA0);
    end

    assign reg_wr     = accept && !is_data && cpu_we;
    assign step_valid = (state == ST_WAIT) && mem_ready;
    assign busy       = (state != ST_IDLE);

    // Sequence the request, memory handshake and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            act_port  <= '0;
        end else begin
            cpu_ack <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept && is_data) begin
                        state     <= ST_WAIT;
                        mem_req   <= 1'b1;
                        mem_we    <= cpu_we;
                        mem_addr  <= ptr_addr[req_port];
                        mem_wdata <= cpu_wdata;
                        act_port  <= req_port;
                    end else if (accept) begin
                        cpu_ack   <= 1'b1;
                        cpu_rdata <= cpu_we ? '0 : reg_rdata;
                    end
                end
                ST_WAIT: begin
                    if (mem_ready) begin
                        state     <= ST_IDLE;
                        mem_req   <= 1'b0;
                        cpu_ack   <= 1'b1;
                        cpu_rdata <= mem_we ? '0 : mem_rdata;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vram_addr_stepper.sv
// Top level: register file with port select, two stepping pointers and
// the access controller. Register loads go to the selected pointer;
// steps go to the pointer of the data port that was accessed.
module vram_addr_stepper
    import vstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_idx,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [16:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);
    logic [NUM_PORTS-1:0][ADDR_W-1:0] ptr_addr;
    logic [NUM_PORTS-1:0]             ptr_decr;
    logic [NUM_PORTS-1:0][CODE_W-1:0] ptr_code;
    logic [PORT_W-1:0]                sel;
    logic [PORT_W-1:0]                act_port;
    logic                             reg_wr;
    logic                             step_valid;
    logic [DATA_W-1:0]                reg_rdata;

    // Hold the port select bit from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (reg_wr && cpu_idx == IDX_CTRL)
            sel <= cpu_wdata[PORT_W-1:0];
    end

    // Read mux for the address and control registers.
    always_comb begin
        case (cpu_idx)
            IDX_LO:   reg_rdata = ptr_addr[sel][7:0];
            IDX_MID:  reg_rdata = ptr_addr[sel][15:8];
            IDX_HI:   reg_rdata = {ptr_code[sel], ptr_decr[sel], 2'b00,
                                   ptr_addr[sel][16]};
            IDX_CTRL: reg_rdata = DATA_W'(sel);
            default:  reg_rdata = '0;
        endcase
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ptr
        logic mine;
        assign mine = reg_wr && (sel == PORT_W'(p));

        vstep_pointer u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_lo   (mine && cpu_idx == IDX_LO),
            .ld_mid  (mine && cpu_idx == IDX_MID),
            .ld_hi   (mine && cpu_idx == IDX_HI),
            .byte_in (cpu_wdata),
            .hi_bit  (cpu_wdata[0]),
            .hi_decr (cpu_wdata[3]),
            .hi_code (cpu_wdata[7:4]),
            .step    (step_valid && act_port == PORT_W'(p)),
            .addr    (ptr_addr[p]),
            .decr    (ptr_decr[p]),
            .code    (ptr_code[p])
        );
    end

    vstep_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_idx    (cpu_idx),
        .cpu_wdata  (cpu_wdata),
        .reg_rdata  (reg_rdata),
        .ptr_addr   (ptr_addr),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .reg_wr     (reg_wr),
        .step_valid (step_valid),
        .act_port   (act_port),
        .busy       (cpu_busy),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/vstep_checker.sv
// Cycle-level properties of the address stepper, bound to the top.
// Assumes the two-port configuration of vstep_pkg.
module vstep_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_busy,
    input logic        cpu_ack,
    input logic        mem_req,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [16:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic [16:0] ptr0,
    input logic [16:0] ptr1,
    input logic        act_port
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !cpu_ack && !cpu_busy));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R4
    req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == (act_port ? ptr1 : ptr0)));

    // R5
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (cpu_ack && !mem_req));

    // R10
    port0_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !act_port) |=> $stable(ptr1));

    // R10
    port1_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && act_port) |=> $stable(ptr0));

    // R11
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy && !mem_ready) |=> ($stable(ptr0) && $stable(ptr1) && !cpu_ack));
endmodule

bind vram_addr_stepper vstep_checker u_vstep_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_busy  (cpu_busy),
    .cpu_ack   (cpu_ack),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ptr0      (ptr_addr[0]),
    .ptr1      (ptr_addr[1]),
    .act_port  (act_port)
);

// File: tb/vram_addr_stepper_test.sv
module vram_addr_stepper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_idx = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ack;
    logic        cpu_busy;
    logic        mem_req;
    logic        mem_we;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int req_cnt = 0;
    bit req_seen = 0;
    bit hold_ready = 0;
    logic [16:0] cap_addr;
    logic        cap_we;
    logic [7:0]  cap_wdata;

    logic [16:0] m_addr [2];
    logic        m_decr [2];
    logic [3:0]  m_code [2];
    logic        m_sel;

    vram_addr_stepper uut (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [16:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction

    function automatic logic [16:0] stride_of(input logic [3:0] c);
        case (c)
            4'd0: return 17'd0;    4'd1: return 17'd1;
            4'd2: return 17'd2;    4'd3: return 17'd4;
            4'd4: return 17'd8;    4'd5: return 17'd16;
            4'd6: return 17'd32;   4'd7: return 17'd64;
            4'd8: return 17'd128;  4'd9: return 17'd256;
            4'd10: return 17'd512; 4'd11: return 17'd40;
            4'd12: return 17'd80;  4'd13: return 17'd160;
            4'd14: return 17'd320; default: return 17'd640;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg(input logic [2:0] idx);
        case (idx)
            3'd0: return m_addr[m_sel][7:0];
            3'd1: return m_addr[m_sel][15:8];
            3'd2: return {m_code[m_sel], m_decr[m_sel], 2'b00, m_addr[m_sel][16]};
            3'd5: return {7'd0, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: random latency, captures each new request once.
    always @(negedge clk) begin
        mem_rdata = mem_byte(mem_addr);
        if (mem_req && !req_seen) begin
            req_seen  = 1;
            req_cnt++;
            cap_addr  = mem_addr;
            cap_we    = mem_we;
            cap_wdata = mem_wdata;
        end
        if (!mem_req) req_seen = 0;
        mem_ready = mem_req && !hold_ready && ($urandom % 3 == 0);
    end

    task automatic do_op(input logic [2:0] idx, input bit we, input logic [7:0] wd,
                         output logic [7:0] rd);
        int n;
        @(negedge clk);
        cpu_req = 1; cpu_idx = idx; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        n = 0;
        while (!cpu_ack && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(cpu_ack, "R5 ack", {31'd0, cpu_ack}, 32'd1);
        rd = cpu_rdata;
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [7:0] wd);
        logic [7:0] rd;
        do_op(idx, 1'b1, wd, rd);
        case (idx)
            3'd0: m_addr[m_sel][7:0] = wd;
            3'd1: m_addr[m_sel][15:8] = wd;
            3'd2: begin
                m_addr[m_sel][16] = wd[0];
                m_decr[m_sel] = wd[3];
                m_code[m_sel] = wd[7:4];
            end
            3'd5: m_sel = wd[0];
            default: ;
        endcase
    endtask

    task automatic reg_check(input logic [2:0] idx, input string tag);
        logic [7:0] rd;
        do_op(idx, 1'b0, 8'h00, rd);
        check(rd == exp_reg(idx), tag, {24'd0, rd}, {24'd0, exp_reg(idx)});
    endtask

    task automatic data_access(input bit port, input bit we, input logic [7:0] wd,
                               input string tag);
        logic [7:0] rd;
        logic [16:0] exp_a;
        int rc;
        exp_a = m_addr[port];
        rc = req_cnt;
        do_op(port ? 3'd4 : 3'd3, we, wd, rd);
        check(req_cnt == rc + 1, "R5 one request", req_cnt, rc + 1);
        check(cap_addr == exp_a, tag, {15'd0, cap_addr}, {15'd0, exp_a});
        check(cap_we == we, "R4 we", {31'd0, cap_we}, {31'd0, we});
        if (we)
            check(cap_wdata == wd, "R4 wdata", {24'd0, cap_wdata}, {24'd0, wd});
        else
            check(rd == mem_byte(exp_a), "R5 rdata", {24'd0, rd},
                  {24'd0, mem_byte(exp_a)});
        m_addr[port] = m_decr[port] ? m_addr[port] - stride_of(m_code[port])
                                    : m_addr[port] + stride_of(m_code[port]);
    endtask

    // Load pointer on the currently selected port.
    task automatic set_ptr(input logic [16:0] a, input bit dec, input logic [3:0] c);
        reg_write(3'd0, a[7:0]);
        reg_write(3'd1, a[15:8]);
        reg_write(3'd2, {c, dec, 2'b00, a[16]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int rc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            m_addr[i] = '0; m_decr[i] = 0; m_code[i] = '0;
        end
        m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check(!mem_req && !cpu_ack && !cpu_busy, "R1 idle outputs",
              {29'd0, mem_req, cpu_ack, cpu_busy}, 32'd0);
        reg_check(3'd0, "R1 lo");
        reg_check(3'd2, "R1 hi");
        reg_check(3'd5, "R1 ctrl");

        // R3: high byte layout, unused bits read zero
        reg_write(3'd2, 8'hF7);
        reg_check(3'd2, "R3 hi layout");
        reg_write(3'd5, 8'hFE);
        reg_check(3'd5, "R3 ctrl unused");
        reg_write(3'd6, 8'hFF);
        reg_check(3'd6, "R3 index6 zero");
        reg_write(3'd2, 8'h00);

        // R6/R7: every stride code, incrementing on port 0
        for (int c = 0; c < 16; c++) begin
            set_ptr(17'h01000, 1'b0, 4'(c));
            data_access(1'b0, 1'b0, 8'h00, c <= 10 ? "R6 stride base" : "R7 stride base");
            data_access(1'b0, 1'b1, 8'(c), c <= 10 ? "R6 stride next" : "R7 stride next");
        end

        // R12: code 0 keeps address
        set_ptr(17'h0ABCD, 1'b0, 4'd0);
        data_access(1'b0, 1'b0, 8'h00, "R12 first");
        data_access(1'b0, 1'b0, 8'h00, "R12 repeat");

        // R8/R9: decrement below zero and increment past top
        set_ptr(17'h00002, 1'b1, 4'd3);
        data_access(1'b0, 1'b0, 8'h00, "R8 dec base");
        data_access(1'b0, 1'b0, 8'h00, "R9 dec wrap");
        check(m_addr[0] == 17'h1FFFA, "R8 model", {15'd0, m_addr[0]}, 32'h1FFFA);
        set_ptr(17'h1FFF0, 1'b0, 4'd15);
        data_access(1'b0, 1'b1, 8'h3C, "R9 inc base");
        data_access(1'b0, 1'b0, 8'h00, "R9 inc wrap");

        // R2/R10: pointer 1 via select, port isolation
        reg_write(3'd5, 8'h01);
        set_ptr(17'h10203, 1'b0, 4'd11);
        reg_check(3'd1, "R2 sel1 mid");
        reg_write(3'd5, 8'h00);
        reg_check(3'd0, "R2 sel0 lo");
        data_access(1'b1, 1'b0, 8'h00, "R10 port1 base");
        data_access(1'b1, 1'b0, 8'h00, "R10 port1 next");
        reg_check(3'd0, "R10 ptr0 untouched lo");
        reg_check(3'd2, "R10 ptr0 untouched hi");

        // R11: request while busy is dropped
        hold_ready = 1;
        rc = req_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_idx = 3'd3; cpu_we = 0;
        @(negedge clk);
        cpu_req = 0;
        @(negedge clk);
        check(cpu_busy && mem_req, "R11 busy", {30'd0, cpu_busy, mem_req}, 32'd3);
        cpu_req = 1; cpu_idx = 3'd0; cpu_we = 1; cpu_wdata = 8'hAA;
        @(negedge clk);
        cpu_req = 0;
        repeat (3) @(negedge clk);
        check(!cpu_ack, "R11 no ack", {31'd0, cpu_ack}, 32'd0);
        hold_ready = 0;
        while (!cpu_ack) @(negedge clk);
        check(req_cnt == rc + 1, "R11 one request", req_cnt, rc + 1);
        m_addr[0] = m_decr[0] ? m_addr[0] - stride_of(m_code[0])
                              : m_addr[0] + stride_of(m_code[0]);
        reg_check(3'd0, "R11 lo not loaded");

        // Random mix of register and data accesses
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 8;
            case (r)
                0, 1, 2: data_access(1'($urandom), 1'($urandom), 8'($urandom),
                                     "R4 random addr");
                3: reg_write(3'd2, 8'($urandom));
                4: reg_write(3'($urandom % 2), 8'($urandom));
                5: reg_write(3'd5, 8'($urandom));
                default: begin
                    logic [2:0] ix;
                    ix = ($urandom % 2) ? 3'($urandom % 3) : (($urandom % 2) ? 3'd5 : 3'd7);
                    reg_check(ix, "R2 random read");
                end
            endcase
        end
        do_op(3'd5, 1'b0, 8'h00, rd);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule